// File: doc/BRIEF.md
# Dual-Mode Serial Register Port

This block is a slave serial port that gives an external host byte access to a 128-location space. The space holds a clock and control bank at the low 32 locations and 96 bytes of general-purpose RAM above it. A mode input picks the electrical style of the link. The first style has separate input and output data wires, as on SPI. The second is a 3-wire style in which the host ties data in to data out and the port releases the line whenever it is not returning read data.

The host raises chip enable and then sends one address byte. Bit 7 of that byte gives the direction: 1 for write, 0 for read. The low seven bits name the location. Data bytes follow, one or many, and the location steps forward after every byte. It wraps at the end of the bank it started in. Locations 12h to 1Fh are reserved. A write-protect bit in the control register at 0Fh blocks every write except a change to that bit itself.

The serial pins are sampled by the block's own clock and edge-detected, so the serial clock must run at well under a quarter of the core clock. The storage lives inside the port. A neighbouring timekeeping block would read it from here.

Top module: `serport_regs`

## Requirements
- R1: When `spi_sel` is 1, `sdo_oe` is high while chip enable is high. When `spi_sel` is 0, `sdo_oe` is high only in the data phase of a read transaction and low during the address byte, during any write, and while chip enable is low.
- R2: Bits travel most significant first. `sdi` is sampled on the rising edge of `sclk`. `sdo` changes only after falling edges and holds steady through the high phase. The first read bit appears after the falling edge that follows the eighth address bit.
- R3: The first byte of a transaction is the address. If its bit 7 is 1 the transaction writes; if bit 7 is 0 it reads. Bits 6:0 select location 0 to 127, so write address 80h+n and read address n reach the same location.
- R4: After each complete data byte the location advances by one. Within locations 00h–1Fh it wraps from 1Fh to 00h. Within 20h–7Fh it wraps from 7Fh to 20h.
- R5: Locations 12h–1Fh always read 0, and writes to them are discarded.
- R6: Bit 6 of location 0Fh is the write-protect bit. While it is 1, every write is discarded, with one exception: a write to 0Fh updates bit 6 only and leaves bits 7 and 5:0 unchanged.
- R7: Dropping chip enable ends the transaction and resets the bit count. A partly shifted byte is discarded and writes nothing, and the next transaction starts again with an address byte.
- R8: After reset every location reads 0, write protect is off, and `sdo` and `sdo_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that samples the serial pins |
| rst_n | input | 1 | Active-low synchronous reset |
| spi_sel | input | 1 | 1 selects separate in/out wires; 0 selects the shared 3-wire line |
| ce | input | 1 | Chip enable, active high for the whole transaction |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data in (the shared line in 3-wire mode) |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Drive enable for `sdo`; a pad uses it to tri-state the line |

## Verification
The bench aims at the two wrap points, 1Fh to 00h and 7Fh to 20h. A design that stepped linearly would run out of the clock bank into RAM, or off the top of the RAM into the clock bank. Reserved locations are written and then read back. A design that stored them would return the written byte instead of zero, and burst reads across 11h–12h show whether the zeroing holds in the middle of a burst. The write-protect tests check that a write to 0Fh under protection changes only bit 6, so that a design that locked itself out or let the other control bits through is caught. Two further corner cases are chip enable dropped after a partial data byte, which must leave the location untouched, and the 3-wire line during the address byte and writes, where a design driving the line would corrupt the host's bits.

// File: rtl/serport_regs.sv
module serport_regs #(
  parameter int DW       = 8,
  parameter int CLK_SPAN = 32,
  parameter int CLK_USED = 18,
  parameter int CTRL_LOC = 15,
  parameter int WP_POS   = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sel,
  input  logic ce,
  input  logic sclk,
  input  logic sdi,
  output logic sdo,
  output logic sdo_oe
);
  localparam int AW    = DW - 1;
  localparam int DEPTH = 1 << AW;
  localparam int BW    = $clog2(DW);
  localparam logic [AW-1:0] SPAN_A = AW'(CLK_SPAN);
  localparam logic [AW-1:0] USED_A = AW'(CLK_USED);
  localparam logic [AW-1:0] CTRL_A = AW'(CTRL_LOC);
  localparam logic [DW-1:0] WP_MASK = DW'(1) << WP_POS;

  logic ce_q, sclk_q, sclk_qq, sdi_q;
  logic [BW-1:0] bit_cnt;
  logic [DW-2:0] in_sr;
  logic [DW-1:0] out_sr;
  logic [AW-1:0] addr;
  logic have_addr, is_wr, rd_phase, sdo_r;
  logic [DW-1:0] mem [DEPTH];

  function automatic logic rsvd(input logic [AW-1:0] a);
    return (a >= USED_A) && (a < SPAN_A);
  endfunction

  function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] a);
    if (a < SPAN_A) return (a == SPAN_A - 1'b1) ? '0 : a + 1'b1;
    return (a == '1) ? SPAN_A : a + 1'b1;
  endfunction

  wire rise     = ce_q & sclk_q & ~sclk_qq;
  wire fall     = ce_q & ~sclk_q & sclk_qq;
  wire last_bit = rise && (bit_cnt == BW'(DW - 1));
  wire [DW-1:0] byte_in = {in_sr, sdi_q};
  wire wp       = mem[CTRL_LOC][WP_POS];

  wire [AW-1:0] rd_addr = have_addr ? next_addr(addr) : byte_in[AW-1:0];
  wire [DW-1:0] rd_data = rsvd(rd_addr) ? '0 : mem[rd_addr];

  wire wr_fire = last_bit && have_addr && is_wr;
  wire mem_we  = wr_fire && !rsvd(addr) && (!wp || addr == CTRL_A);
  wire [DW-1:0] wr_word = wp ? ((mem[addr] & ~WP_MASK) | (byte_in & WP_MASK)) : byte_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce_q    <= 1'b0;
      sclk_q  <= 1'b0;
      sclk_qq <= 1'b0;
      sdi_q   <= 1'b0;
    end else begin
      ce_q    <= ce;
      sclk_q  <= sclk;
      sclk_qq <= sclk_q;
      sdi_q   <= sdi;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      in_sr     <= '0;
      out_sr    <= '0;
      addr      <= '0;
      have_addr <= 1'b0;
      is_wr     <= 1'b0;
      rd_phase  <= 1'b0;
      sdo_r     <= 1'b0;
    end else if (!ce_q) begin
      bit_cnt   <= '0;
      have_addr <= 1'b0;
      is_wr     <= 1'b0;
      rd_phase  <= 1'b0;
      sdo_r     <= 1'b0;
    end else begin
      if (rise) begin
        in_sr   <= byte_in[DW-2:0];
        bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
      end
      if (last_bit) begin
        if (!have_addr) begin
          have_addr <= 1'b1;
          addr      <= byte_in[AW-1:0];
          is_wr     <= byte_in[DW-1];
          rd_phase  <= !byte_in[DW-1];
          out_sr    <= rd_data;
        end else begin
          addr <= next_addr(addr);
          if (!is_wr) out_sr <= rd_data;
        end
      end
      if (fall && rd_phase) begin
        sdo_r  <= out_sr[DW-1];
        out_sr <= {out_sr[DW-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (mem_we) begin
      mem[addr] <= wr_word;
    end
  end

  assign sdo    = sdo_r;
  assign sdo_oe = spi_sel ? ce_q : rd_phase;
endmodule

module serport_regs_chk #(
  parameter int DW       = 8,
  parameter int CLK_SPAN = 32,
  parameter int CLK_USED = 18,
  parameter int CTRL_LOC = 15,
  parameter int BW       = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          spi_sel,
  input logic          ce,
  input logic          ce_q,
  input logic          sdo,
  input logic          sdo_oe,
  input logic          rise,
  input logic          last_bit,
  input logic          have_addr,
  input logic [DW-2:0] addr,
  input logic [BW-1:0] bit_cnt,
  input logic          mem_we,
  input logic          wp
);
  localparam logic [DW-2:0] SPAN_A = (DW-1)'(CLK_SPAN);
  localparam logic [DW-2:0] USED_A = (DW-1)'(CLK_USED);
  localparam logic [DW-2:0] CTRL_A = (DW-1)'(CTRL_LOC);

  p_oe_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_sel && !have_addr) |-> !sdo_oe);

  p_sdo_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && ce) |=> $stable(sdo));

  p_wrap_clk_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (have_addr && last_bit && addr < SPAN_A) |=> addr < SPAN_A);

  p_wrap_ram_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (have_addr && last_bit && addr >= SPAN_A) |=> addr >= SPAN_A);

  p_no_rsvd_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !(addr >= USED_A && addr < SPAN_A));

  p_wp_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && wp) |-> addr == CTRL_A);

  p_ce_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_q |=> (bit_cnt == '0 && !have_addr));
endmodule

bind serport_regs serport_regs_chk #(
  .DW(DW), .CLK_SPAN(CLK_SPAN), .CLK_USED(CLK_USED), .CTRL_LOC(CTRL_LOC), .BW(BW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_sel(spi_sel), .ce(ce), .ce_q(ce_q),
  .sdo(sdo), .sdo_oe(sdo_oe), .rise(rise), .last_bit(last_bit),
  .have_addr(have_addr), .addr(addr), .bit_cnt(bit_cnt),
  .mem_we(mem_we), .wp(wp)
);

// File: tb/test_serport_regs.sv
module test_serport_regs;
  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_sel = 1'b1, ce = 1'b0, sclk = 1'b0, host_d = 1'b0;
  logic sdo, sdo_oe;
  wire  sdi_w = (!spi_sel && sdo_oe) ? sdo : host_d;

  int checks = 0, fails = 0, stab_bad = 0;
  bit done = 0;
  logic [7:0] mdl [128];
  logic [7:0] wbuf [8];

  always #4 clk = ~clk;

  serport_regs i_serport_regs (
    .clk(clk), .rst_n(rst_n), .spi_sel(spi_sel), .ce(ce), .sclk(sclk),
    .sdi(sdi_w), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  function automatic bit f_rsvd(input logic [6:0] a);
    return a >= 7'h12 && a <= 7'h1F;
  endfunction

  function automatic logic [6:0] f_next(input logic [6:0] a);
    if (a == 7'h1F) return 7'h00;
    if (a == 7'h7F) return 7'h20;
    return a + 7'd1;
  endfunction

  function automatic logic [7:0] f_read(input logic [6:0] a);
    return f_rsvd(a) ? 8'h00 : mdl[a];
  endfunction

  task automatic m_write(input logic [6:0] a, input logic [7:0] d);
    if (f_rsvd(a)) return;
    if (mdl[7'h0F][6]) begin
      if (a == 7'h0F) mdl[a][6] = d[6];
    end else mdl[a] = d;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xbyte(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      host_d = tx[i];
      wait_n(4);
      rx[i] = sdo;
      sclk = 1'b1;
      wait_n(4);
      if (sdo !== rx[i]) stab_bad++;
      sclk = 1'b0;
    end
    wait_n(4);
  endtask

  task automatic end_tx();
    ce = 1'b0;
    wait_n(6);
  endtask

  task automatic tx_write(input logic [6:0] a, input int n, input string req);
    logic [7:0] rx;
    logic [6:0] p = a;
    ce = 1'b1;
    wait_n(4);
    xbyte({1'b1, a}, 8, rx);
    check({req, " oe during write"}, sdo_oe, spi_sel);
    for (int k = 0; k < n; k++) begin
      xbyte(wbuf[k], 8, rx);
      m_write(p, wbuf[k]);
      p = f_next(p);
    end
    end_tx();
  endtask

  task automatic tx_read(input logic [6:0] a, input int n, input string req);
    logic [7:0] rx;
    logic [6:0] p = a;
    ce = 1'b1;
    wait_n(4);
    xbyte({1'b0, a}, 8, rx);
    check("R1 oe in read data phase", sdo_oe, 1'b1);
    for (int k = 0; k < n; k++) begin
      xbyte($urandom, 8, rx);
      check(req, {p, rx}, {p, f_read(p)});
      p = f_next(p);
    end
    end_tx();
  endtask

  initial begin
    logic [7:0] rx;
    int seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    for (int i = 0; i < 128; i++) mdl[i] = 8'h00;
    wait_n(5);
    check("R8 reset sdo_oe", sdo_oe, 1'b0);
    check("R8 reset sdo", sdo, 1'b0);
    rst_n = 1'b1;
    wait_n(3);
    tx_read(7'h05, 2, "R8 reset contents");
    tx_read(7'h0F, 1, "R8 reset control");

    wbuf[0] = 8'hA5;
    tx_write(7'h25, 1, "R3");
    tx_read(7'h25, 1, "R3 read/write alias");
    tx_read(7'h24, 1, "R3 neighbour untouched");

    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    tx_write(7'h7E, 3, "R4");
    tx_read(7'h7E, 3, "R4 ram wrap 7F->20");
    check("R4 ram wrap stored at 20", mdl[7'h20], 8'h33);

    wbuf[0] = 8'h44; wbuf[1] = 8'h55; wbuf[2] = 8'h66; wbuf[3] = 8'h77;
    tx_write(7'h1E, 4, "R4");
    tx_read(7'h1E, 4, "R4 clock wrap 1F->00");
    check("R4 clock wrap stored at 01", mdl[7'h01], 8'h77);

    wbuf[0] = 8'h81; wbuf[1] = 8'h82; wbuf[2] = 8'h83;
    tx_write(7'h10, 3, "R5");
    tx_read(7'h10, 4, "R5 reserved reads zero in burst");
    wbuf[0] = 8'hFF;
    tx_write(7'h15, 1, "R5");
    tx_read(7'h15, 1, "R5 reserved write ignored");

    wbuf[0] = 8'h9B;
    tx_write(7'h0F, 1, "R6");
    wbuf[0] = 8'h40;
    tx_write(7'h0F, 1, "R6");
    wbuf[0] = 8'hEE;
    tx_write(7'h30, 1, "R6");
    tx_read(7'h30, 1, "R6 ram write blocked");
    wbuf[0] = 8'hEE;
    tx_write(7'h02, 1, "R6");
    tx_read(7'h02, 1, "R6 clock write blocked");
    wbuf[0] = 8'h3F;
    tx_write(7'h0F, 1, "R6");
    tx_read(7'h0F, 1, "R6 only bit 6 changed");
    check("R6 control after unprotect", mdl[7'h0F], 8'h00);
    wbuf[0] = 8'h5A;
    tx_write(7'h30, 1, "R6");
    tx_read(7'h30, 1, "R6 write after unprotect");

    ce = 1'b1; wait_n(4);
    xbyte(8'hB0, 8, rx);
    xbyte(8'hC3, 5, rx);
    end_tx();
    check("R7 oe low after ce drop", sdo_oe, 1'b0);
    tx_read(7'h30, 1, "R7 partial byte discarded");
    ce = 1'b1; wait_n(4);
    xbyte(8'hB1, 3, rx);
    end_tx();
    wbuf[0] = 8'h6C;
    tx_write(7'h31, 1, "R7");
    tx_read(7'h31, 1, "R7 count reset after partial address");

    spi_sel = 1'b0;
    ce = 1'b1; wait_n(4);
    check("R1 3-wire oe low in address byte", sdo_oe, 1'b0);
    end_tx();
    wbuf[0] = 8'hC6; wbuf[1] = 8'h39;
    tx_write(7'h40, 2, "R1");
    tx_read(7'h40, 2, "R1 3-wire read");
    check("R1 3-wire oe released", sdo_oe, 1'b0);

    for (int t = 0; t < 60; t++) begin
      logic [6:0] a;
      int n;
      spi_sel = $urandom_range(1, 0);
      a = $urandom;
      n = $urandom_range(4, 1);
      if ($urandom_range(1, 0) == 1) begin
        for (int k = 0; k < n; k++) begin
          wbuf[k] = $urandom;
          if (($urandom_range(7, 0)) != 0) wbuf[k][6] = 1'b0;
        end
        tx_write(a, n, "R3 random write");
      end else tx_read(a, n, "R4 random read");
    end
    for (int i = 0; i < 128; i += 8) tx_read(7'(i), 8, "R5 final sweep");

    check("R2 sdo steady while sclk high", stab_bad, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule